// File: doc/BRIEF.md
# DMA Channel Enable and Termination Control

This block is the control core of a single DMA channel. It holds the channel's enable bit, its end-of-transfer flag, an interrupt-enable bit, a request-mode bit and a 24-bit transfer counter. From these, and from a global master-enable input and an NMI-flag input, it decides in each cycle whether the channel may move one unit of data. When it may, it raises a one-cycle grant strobe. Address generation, bus cycles and arbitration between channels are handled by other blocks.

Software programs the channel through a small register port with a write strobe, a read strobe and a two-bit address. In auto mode the channel issues a grant on every cycle once it is enabled and not blocked. In external mode it issues a grant only in a cycle where the request strobe is high. Each grant decrements the counter by one. When the last programmed transfer is granted, the end flag sets and can raise an interrupt. The end flag can only be cleared by the handshake of reading it as 1 and then writing 0. An early stop never sets the flag: an address error, a cleared enable, a cleared master enable or a set NMI flag all leave it at 0.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the enable bit, end flag, interrupt enable, mode bit and counter are all 0, and grant and irq are low.
- R2: Reads return data combinationally in the same cycle. Address 0 is the control word: bit 0 is channel enable, bit 1 is the end flag, bit 2 is interrupt enable, and bit 3 selects external mode (1) or auto mode (0). Address 1 holds the counter in bits 23:0. All other bits and addresses read as 0.
- R3: In auto mode, grant is high on every cycle in which the channel is enabled and unblocked, starting in the cycle after the write that sets the enable bit.
- R4: In external mode, grant is high only in a cycle where xferReq is high and the channel is enabled and unblocked. A request seen while the enable bit is 0 produces no grant, either then or later.
- R5: Each grant decrements the counter by exactly one. The end flag sets on the clock edge that ends the cycle in which the grant is issued with the counter at 1, and no further grants follow. A counter loaded with 0 means 2^24 transfers, so one grant leaves it at 0xFFFFFF.
- R6: irq is high exactly while both the end flag and the interrupt enable are 1.
- R7: A write of 0 to the end flag clears it only if the flag was read as 1 since it was set. A write of 1, or a write of 0 without that read, leaves it unchanged.
- R8: While masterEn is 0 or nmiFlag is 1, grant stays low and the end flag does not set.
- R9: Writing 0 to the enable bit stops grants from the next cycle on and leaves the end flag at 0.
- R10: When addrErr is high, grant is low in that cycle, the enable bit is 0 from the next cycle on, and the end flag stays 0.
- R11: While the end flag is 1, grant stays low even after the enable bit is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data (combinational) |
| masterEn | input | 1 | Global DMA master enable |
| nmiFlag | input | 1 | NMI flag; blocks the channel while high |
| addrErr | input | 1 | Address error; aborts the channel |
| xferReq | input | 1 | External transfer request strobe |
| grant | output | 1 | One-cycle transfer grant |
| irq | output | 1 | Transfer-end interrupt request |
| chanOn | output | 1 | Channel enable bit |
| endFlag | output | 1 | Transfer-end flag |

## Verification
The assertions check on every cycle that grant never appears while the master enable is low, the NMI flag is set, the channel is off or the end flag is up. They also check that the end flag rises only after a grant taken at a count of one, that it falls only after the read-then-write-0 handshake, that an address error always drops the enable, and that each grant lowers the counter by one. The bench scenarios show the rest: the mode-dependent grant patterns, a request that arrives before enable being dropped, the wrap to 0xFFFFFF from a zero count, the exact grant total before the end flag sets, and the ignored flag writes.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  // control word bit positions (software decodes these)
  localparam int CTL_EN  = 0;
  localparam int CTL_END = 1;
  localparam int CTL_IE  = 2;
  localparam int CTL_EXT = 3;

  localparam logic [1:0] ADR_CTL = 2'd0;
  localparam logic [1:0] ADR_CNT = 2'd1;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;
    logic dec;
  } cntStb_t;
endpackage

// File: rtl/dmach_count.sv
`timescale 1ns/1ps
module dmach_count
  import dmach_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStb_t          stb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             lastOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // a loaded 0 wraps to all-ones on the first grant, giving 2^CNT_W transfers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (stb.load) cnt <= loadVal;
    else if (stb.dec)  cnt <= cnt - ONE;
  end

  assign lastOne = (cnt == ONE);

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dec && !stb.load) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/dmach_ctrl.sv
`timescale 1ns/1ps
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              masterEn,
  input  logic              nmiFlag,
  input  logic              addrErr,
  input  logic              xferReq,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              lastOne,
  output cntStb_t           stb,
  output logic [CNT_W-1:0]  loadVal,
  output logic              grant,
  output logic              irq,
  output logic              chanOn,
  output logic              endFlag
);
  logic intEn, extMode, rdSeen;
  logic ctlWr, cntWr, ctlRd, gateOk, finish, clrEnd;
  logic unusedHigh;

  assign ctlWr = regWrEn && (regAddr == ADR_CTL);
  assign cntWr = regWrEn && (regAddr == ADR_CNT);
  assign ctlRd = regRdEn && (regAddr == ADR_CTL);

  assign loadVal    = regWrData[CNT_W-1:0];
  assign unusedHigh = ^regWrData[DATA_W-1:CNT_W];

  // channel may move data only if every gate is open
  assign gateOk = chanOn && !endFlag && masterEn && !nmiFlag && !addrErr;
  assign grant  = gateOk && (extMode ? xferReq : 1'b1);
  assign finish = grant && lastOne;
  assign clrEnd = ctlWr && !regWrData[CTL_END] && rdSeen;

  assign stb.dec  = grant;
  assign stb.load = cntWr;
  assign irq      = endFlag && intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanOn  <= 1'b0;
      intEn   <= 1'b0;
      extMode <= 1'b0;
    end else begin
      if (addrErr)    chanOn <= 1'b0;
      else if (ctlWr) chanOn <= regWrData[CTL_EN];
      if (ctlWr) begin
        intEn   <= regWrData[CTL_IE];
        extMode <= regWrData[CTL_EXT];
      end
    end
  end

  // end flag: set on count exhaustion, cleared only by read-1 then write-0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endFlag <= 1'b0;
      rdSeen  <= 1'b0;
    end else if (finish) begin
      endFlag <= 1'b1;
    end else if (clrEnd) begin
      endFlag <= 1'b0;
      rdSeen  <= 1'b0;
    end else if (ctlRd && endFlag) begin
      rdSeen  <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_CTL: begin
        regRdData[CTL_EN]  = chanOn;
        regRdData[CTL_END] = endFlag;
        regRdData[CTL_IE]  = intEn;
        regRdData[CTL_EXT] = extMode;
      end
      ADR_CNT: regRdData[CNT_W-1:0] = cnt;
      default: regRdData = '0;
    endcase
  end

  // R8
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> (masterEn && !nmiFlag && chanOn));
  // R11
  ended_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    endFlag |-> !grant);
  // R5
  end_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> $past(grant && lastOne));
  // R7
  end_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(endFlag) |-> $past(ctlWr && !regWrData[CTL_END] && rdSeen));
  // R10
  abort_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> !chanOn);
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dmach_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              masterEn,
  input  logic              nmiFlag,
  input  logic              addrErr,
  input  logic              xferReq,
  output logic              grant,
  output logic              irq,
  output logic              chanOn,
  output logic              endFlag
);
  cntStb_t          stb;
  logic [CNT_W-1:0] cnt, loadVal;
  logic             lastOne;

  dmach_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .masterEn(masterEn), .nmiFlag(nmiFlag), .addrErr(addrErr),
    .xferReq(xferReq), .cnt(cnt), .lastOne(lastOne), .stb(stb),
    .loadVal(loadVal), .grant(grant), .irq(irq), .chanOn(chanOn),
    .endFlag(endFlag)
  );

  dmach_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(loadVal),
    .cnt(cnt), .lastOne(lastOne)
  );
endmodule

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        masterEn = 1'b1, nmiFlag = 1'b0, addrErr = 1'b0, xferReq = 1'b0;
  logic        grant, irq, chanOn, endFlag;

  int total = 0, bad = 0, grantCnt = 0, g0 = 0;
  logic [31:0] rdv;

  always #2.5 clk = ~clk;

  dma_chan_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .masterEn(masterEn), .nmiFlag(nmiFlag), .addrErr(addrErr),
    .xferReq(xferReq), .grant(grant), .irq(irq), .chanOn(chanOn),
    .endFlag(endFlag)
  );

  always @(posedge clk) if (rstN && grant) grantCnt <= grantCnt + 1;

  typedef struct packed {
    logic mEn; logic nmi; logic req; logic aerr; logic expG;
  } vec_t;
  // external mode, channel enabled, counter 100
  localparam vec_t VECS [0:7] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 grant", grant, 0);
    chk("R1 irq", irq, 0);
    chk("R1 chanOn", chanOn, 0);
    chk("R1 endFlag", endFlag, 0);
    rd(2'd1, rdv); chk("R1 count", rdv, 0);
    rd(2'd0, rdv); chk("R1 ctl", rdv, 0);

    // vector table: external mode gating and abort
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h9);
    rd(2'd0, rdv); chk("R2 ctl readback", rdv, 32'h9);
    rd(2'd2, rdv); chk("R2 unused addr", rdv, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      masterEn = VECS[i].mEn; nmiFlag = VECS[i].nmi;
      xferReq = VECS[i].req; addrErr = VECS[i].aerr;
      #1 chk($sformatf("R4/R8/R10 vec%0d grant", i), grant, VECS[i].expG);
    end
    @(negedge clk); masterEn = 1'b1; nmiFlag = 1'b0; xferReq = 1'b0; addrErr = 1'b0;
    chk("R10 chanOn", chanOn, 0);
    chk("R10 endFlag", endFlag, 0);
    rd(2'd1, rdv); chk("R5 count after 2 grants", rdv, 32'd98);

    // R4: request before enable is dropped
    @(negedge clk); xferReq = 1'b1;
    #1 chk("R4 req while off", grant, 0);
    @(negedge clk); xferReq = 1'b0;
    wr(2'd0, 32'h9);
    g0 = grantCnt;
    repeat (4) @(negedge clk);
    chk("R4 no late grant", grantCnt - g0, 0);
    @(negedge clk); xferReq = 1'b1;
    #1 chk("R4 req while on", grant, 1);
    @(negedge clk); xferReq = 1'b0;

    // R5: zero count means 2^24
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h9);
    @(negedge clk); xferReq = 1'b1;
    @(negedge clk); xferReq = 1'b0;
    rd(2'd1, rdv); chk("R5 wrap", rdv, 32'hFFFFFF);
    chk("R5 no end on wrap", endFlag, 0);
    wr(2'd0, 32'h0);

    // R3/R5/R6: auto mode runs to the end
    wr(2'd1, 32'd3);
    g0 = grantCnt;
    wr(2'd0, 32'h5);
    #1 chk("R3 auto grant", grant, 1);
    repeat (6) @(negedge clk);
    chk("R5 grant total", grantCnt - g0, 3);
    chk("R5 endFlag", endFlag, 1);
    chk("R6 irq", irq, 1);
    rd(2'd1, rdv); chk("R5 count zero", rdv, 0);

    // R7/R11: flag clear handshake
    wr(2'd0, 32'h4);
    chk("R7 write0 without read", endFlag, 1);
    chk("R6 irq held", irq, 1);
    wr(2'd0, 32'h6);
    chk("R7 write1 ignored", endFlag, 1);
    g0 = grantCnt;
    wr(2'd0, 32'h5);
    repeat (3) @(negedge clk);
    chk("R11 no grant while ended", grantCnt - g0, 0);
    chk("R11 chanOn", chanOn, 1);
    rd(2'd0, rdv); chk("R2 ctl ended", rdv, 32'h7);
    wr(2'd0, 32'h4);
    chk("R7 cleared", endFlag, 0);
    chk("R6 irq low", irq, 0);

    // R8: master enable and NMI gate
    wr(2'd1, 32'd10);
    @(negedge clk); masterEn = 1'b0;
    wr(2'd0, 32'h1);
    g0 = grantCnt;
    repeat (3) @(negedge clk);
    chk("R8 master off", grantCnt - g0, 0);
    @(negedge clk); masterEn = 1'b1;
    #1 chk("R8 master on", grant, 1);
    @(negedge clk); nmiFlag = 1'b1;
    #1 chk("R8 nmi", grant, 0);
    g0 = grantCnt;
    repeat (3) @(negedge clk);
    chk("R8 nmi hold", grantCnt - g0, 0);
    chk("R8 endFlag", endFlag, 0);
    @(negedge clk); nmiFlag = 1'b0;

    // R9: clearing enable stops transfers
    wr(2'd0, 32'h0);
    #1 chk("R9 grant", grant, 0);
    chk("R9 chanOn", chanOn, 0);
    chk("R9 endFlag", endFlag, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule